// File: doc/BRIEF.md
# Dual Timer/Counter Pair with Selectable Prescale

This block holds two classic microcontroller-style timer/counters, named timer A (index 0) and timer B (index 1). Each one is a pair of 8-bit count registers (low byte and high byte) with a 2-bit mode field, a source select (prescaled clock or external pin), a gate enable, a run bit and an overflow flag. In timer mode each timer advances on a prescaled clock tick, and each timer has its own choice of a 12-clock or a 4-clock tick. In counter mode it advances once per falling edge of its external pin.

Software reaches the block through a write port and a registered read port. Timer B overflows also leave the block as a one-cycle baud tick, which a serial port elsewhere can use. Mode 3 on timer A splits it into two independent 8-bit counters. In that mode the high byte of timer A takes over timer B's run bit and overflow flag, and timer B is then started and stopped through its mode field alone.

Top module: `tmr_pair`

## Requirements
- R1: In timer mode (source select 0), a running timer advances exactly once every 12 clocks while its fast bit is 0 and once every 4 clocks while it is 1. The fast bits sit in the clock-select register (address 6): bit 3 for timer A and bit 4 for timer B.
- R2: In counter mode (source select 1), a timer advances once for each falling edge of its pin, seen through a two-flop synchronizer as a 1 followed by a 0. The fast bit has no effect in this mode.
- R3: Mode 0 is 13 bits: the high byte plus low-byte bits 4..0, with low-byte bits 7..5 held. Mode 1 is a 16-bit count. Mode 2 counts the low byte and reloads it from the high byte on overflow. Each wrap sets that timer's overflow flag.
- R4: A timer advances only while its run bit is 1 and either its gate enable is 0 or its gate pin is high.
- R5: A register write takes priority over an increment in the same cycle. Writing the control register loads both overflow flags, so software can clear or set them.
- R6: In timer A mode 3, the low byte is an 8-bit counter under timer A's run bit, gate and source select, and it sets flag A when it wraps. The high byte counts only prescaled clock ticks at timer A's rate. It is enabled by timer B's run bit and sets flag B when it wraps.
- R7: While timer A is in mode 3, timer B counts whenever its mode is 0, 1 or 2, whatever its run bit, and it holds in mode 3. It keeps its gate, source select and prescale. Its wraps leave flag B untouched.
- R8: Every wrap of timer B gives exactly one single-cycle pulse on baud_tick, whether or not timer A is in split mode.
- R9: Register map (addresses 0-6): count registers A-low, A-high, B-low and B-high. Mode register: timer A in bits 3..0 and timer B in bits 7..4, each as {gate, source, mode[1:0]}. Control: bit0 run A, bit1 flag A, bit2 run B, bit3 flag B. Clock select as in R1. After reset, every register, both flags and baud_tick are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Registered read data, one cycle after rd_addr |
| cnt_pin0 | input | 1 | External count pin, timer A |
| cnt_pin1 | input | 1 | External count pin, timer B |
| gate_pin0 | input | 1 | Gate pin, timer A |
| gate_pin1 | input | 1 | Gate pin, timer B |
| ovf0_flag | output | 1 | Overflow flag A |
| ovf1_flag | output | 1 | Overflow flag B (split mode: high byte of A) |
| baud_tick | output | 1 | One-cycle pulse per timer B wrap |

## Verification
The hardest case to reach is a register write that lands in the same clock as an increment. This needs the synchronizer latency to be counted exactly. The stimulus drops the pin and then issues the write two cycles later, so that it meets the edge-driven increment. Rate checks do not depend on the prescaler phase: they read a count twice, a fixed whole number of prescale periods apart. Random preloads and edge counts in every mode are compared with a stepwise model in the bench, which also counts wraps and baud pulses. Split mode is driven through each of timer B's modes and run states.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;

  typedef enum logic [1:0] {
    MODE_13B       = 2'd0,
    MODE_16B       = 2'd1,
    MODE_8B_RELOAD = 2'd2,
    MODE_SPLIT     = 2'd3
  } tmr_mode_e;

  // per-timer configuration nibble: {gate, source, mode}
  typedef struct packed {
    logic      gate;
    logic      ext_src;
    tmr_mode_e mode;
  } tmr_cfg_t;

  localparam int REG_A_LO  = 0;
  localparam int REG_A_HI  = 1;
  localparam int REG_B_LO  = 2;
  localparam int REG_B_HI  = 3;
  localparam int REG_MODE  = 4;
  localparam int REG_CTRL  = 5;
  localparam int REG_CKSEL = 6;

  localparam int CTRL_RUN_A  = 0;
  localparam int CTRL_FLAG_A = 1;
  localparam int CTRL_RUN_B  = 2;
  localparam int CTRL_FLAG_B = 3;

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES    = 2,
  parameter bit EDGE_MODE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  output logic sig_out
);

  logic [STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[STAGES-1:0], pin_in};
  end

  generate
    if (EDGE_MODE) begin : g_fall
      assign sig_out = shreg[STAGES] & ~shreg[STAGES-1];
    end else begin : g_level
      assign sig_out = shreg[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fast,
  output logic tick
);

  localparam int CW = $clog2(SLOW_DIV);
  localparam logic [CW-1:0] LIM_SLOW = CW'(SLOW_DIV - 1);
  localparam logic [CW-1:0] LIM_FAST = CW'(FAST_DIV - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = fast ? LIM_FAST : LIM_SLOW;
  assign tick = (cnt >= lim);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/tmr_count_engine.sv
module tmr_count_engine
  import tmr_pair_pkg::*;
#(
  parameter int W       = 8,
  parameter int M0_BITS = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  tmr_mode_e    mode,
  input  logic         lo_inc,
  input  logic         hi_inc,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic         wrap
);

  localparam logic [W-1:0]       ALL1    = '1;
  localparam logic [M0_BITS-1:0] M0_ALL1 = '1;

  logic [W-1:0] lo_n, hi_n;

  always_comb begin
    lo_n = lo;
    hi_n = hi;
    wrap = 1'b0;
    unique case (mode)
      MODE_13B: begin
        if (lo_inc) begin
          if (lo[M0_BITS-1:0] == M0_ALL1) begin
            lo_n[M0_BITS-1:0] = '0;
            hi_n = hi + 1'b1;
            wrap = (hi == ALL1);
          end else begin
            lo_n[M0_BITS-1:0] = lo[M0_BITS-1:0] + 1'b1;
          end
        end
      end
      MODE_16B: begin
        if (lo_inc) begin
          {hi_n, lo_n} = {hi, lo} + 1'b1;
          wrap = (lo == ALL1) && (hi == ALL1);
        end
      end
      MODE_8B_RELOAD: begin
        if (lo_inc) begin
          if (lo == ALL1) begin
            lo_n = hi;
            wrap = 1'b1;
          end else begin
            lo_n = lo + 1'b1;
          end
        end
      end
      MODE_SPLIT: begin
        if (lo_inc) begin
          lo_n = lo + 1'b1;
          wrap = (lo == ALL1);
        end
        if (hi_inc) hi_n = hi + 1'b1;
      end
    endcase
    if (wr_lo) lo_n = wr_data;
    if (wr_hi) hi_n = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_n;
      hi <= hi_n;
    end
  end

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pair_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int PS_SLOW     = 12,
  parameter int PS_FAST     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int M0_BITS     = 5,
  parameter int FAST_A_BIT  = 3,
  parameter int FAST_B_BIT  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cnt_pin0,
  input  logic              cnt_pin1,
  input  logic              gate_pin0,
  input  logic              gate_pin1,
  output logic              ovf0_flag,
  output logic              ovf1_flag,
  output logic              baud_tick
);

  localparam int NT   = 2;
  localparam int NPIN = 2 * NT;
  localparam logic [ADDR_W-1:0] A_ALO  = ADDR_W'(REG_A_LO);
  localparam logic [ADDR_W-1:0] A_AHI  = ADDR_W'(REG_A_HI);
  localparam logic [ADDR_W-1:0] A_BLO  = ADDR_W'(REG_B_LO);
  localparam logic [ADDR_W-1:0] A_BHI  = ADDR_W'(REG_B_HI);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(REG_MODE);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_CKS  = ADDR_W'(REG_CKSEL);

  // synchronized pins: [1:0] count edges, [3:2] gate levels
  logic [NPIN-1:0] pin_raw, pin_syn;
  assign pin_raw = {gate_pin1, gate_pin0, cnt_pin1, cnt_pin0};

  genvar gi;
  generate
    for (gi = 0; gi < NPIN; gi++) begin : g_sync
      tmr_pin_sync #(
        .STAGES   (SYNC_STAGES),
        .EDGE_MODE(gi < NT)
      ) i_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_raw[gi]),
        .sig_out(pin_syn[gi])
      );
    end
  endgenerate

  // configuration and control state
  tmr_cfg_t        cfg [NT];
  logic [NT-1:0]   run, fast, ps_tick;
  logic            ctrl_wr, mode_wr, cks_wr;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign mode_wr = wr_en && (wr_addr == A_MODE);
  assign cks_wr  = wr_en && (wr_addr == A_CKS);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg[0] <= '0;
      cfg[1] <= '0;
      run    <= '0;
      fast   <= '0;
    end else begin
      if (mode_wr) begin
        cfg[0] <= tmr_cfg_t'(wr_data[3:0]);
        cfg[1] <= tmr_cfg_t'(wr_data[7:4]);
      end
      if (ctrl_wr) begin
        run[0] <= wr_data[CTRL_RUN_A];
        run[1] <= wr_data[CTRL_RUN_B];
      end
      if (cks_wr) begin
        fast[0] <= wr_data[FAST_A_BIT];
        fast[1] <= wr_data[FAST_B_BIT];
      end
    end
  end

  generate
    for (gi = 0; gi < NT; gi++) begin : g_ps
      tmr_prescaler #(
        .SLOW_DIV(PS_SLOW),
        .FAST_DIV(PS_FAST)
      ) i_ps (
        .clk (clk),
        .rst (rst),
        .fast(fast[gi]),
        .tick(ps_tick[gi])
      );
    end
  endgenerate

  // count enables and split-mode steering
  logic          split;
  logic [NT-1:0] gate_ok, src_ev, lo_inc, wrap;
  logic          hi_a_inc, b_on, hi_a_wrap;

  assign split = (cfg[0].mode == MODE_SPLIT);

  generate
    for (gi = 0; gi < NT; gi++) begin : g_en
      assign gate_ok[gi] = ~cfg[gi].gate | pin_syn[NT + gi];
      assign src_ev[gi]  = cfg[gi].ext_src ? pin_syn[gi] : ps_tick[gi];
    end
  endgenerate

  assign b_on      = split ? 1'b1 : run[1];
  assign lo_inc[0] = run[0] & gate_ok[0] & src_ev[0];
  assign lo_inc[1] = b_on & (cfg[1].mode != MODE_SPLIT) & gate_ok[1] & src_ev[1];
  assign hi_a_inc  = split & run[1] & ps_tick[0];

  logic [DATA_W-1:0] a_lo, a_hi, b_lo, b_hi;

  tmr_count_engine #(.W(DATA_W), .M0_BITS(M0_BITS)) i_eng_a (
    .clk    (clk),
    .rst    (rst),
    .mode   (cfg[0].mode),
    .lo_inc (lo_inc[0]),
    .hi_inc (hi_a_inc),
    .wr_lo  (wr_en && (wr_addr == A_ALO)),
    .wr_hi  (wr_en && (wr_addr == A_AHI)),
    .wr_data(wr_data),
    .lo     (a_lo),
    .hi     (a_hi),
    .wrap   (wrap[0])
  );

  tmr_count_engine #(.W(DATA_W), .M0_BITS(M0_BITS)) i_eng_b (
    .clk    (clk),
    .rst    (rst),
    .mode   (cfg[1].mode),
    .lo_inc (lo_inc[1]),
    .hi_inc (1'b0),
    .wr_lo  (wr_en && (wr_addr == A_BLO)),
    .wr_hi  (wr_en && (wr_addr == A_BHI)),
    .wr_data(wr_data),
    .lo     (b_lo),
    .hi     (b_hi),
    .wrap   (wrap[1])
  );

  assign hi_a_wrap = hi_a_inc & (a_hi == '1);

  // flags and baud tick
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf0_flag <= 1'b0;
      ovf1_flag <= 1'b0;
      baud_tick <= 1'b0;
    end else begin
      baud_tick <= wrap[1];
      if (ctrl_wr) begin
        ovf0_flag <= wr_data[CTRL_FLAG_A];
        ovf1_flag <= wr_data[CTRL_FLAG_B];
      end else begin
        if (wrap[0]) ovf0_flag <= 1'b1;
        if (split ? hi_a_wrap : wrap[1]) ovf1_flag <= 1'b1;
      end
    end
  end

  // registered read port
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    unique case (rd_addr)
      A_ALO:  rd_mux = a_lo;
      A_AHI:  rd_mux = a_hi;
      A_BLO:  rd_mux = b_lo;
      A_BHI:  rd_mux = b_hi;
      A_MODE: rd_mux = DATA_W'({cfg[1], cfg[0]});
      A_CTRL: begin
        rd_mux[CTRL_RUN_A]  = run[0];
        rd_mux[CTRL_FLAG_A] = ovf0_flag;
        rd_mux[CTRL_RUN_B]  = run[1];
        rd_mux[CTRL_FLAG_B] = ovf1_flag;
      end
      A_CKS: begin
        rd_mux[FAST_A_BIT] = fast[0];
        rd_mux[FAST_B_BIT] = fast[1];
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [1:0] mode_a,
  input logic [1:0] mode_b,
  input logic       run_a,
  input logic [7:0] a_lo,
  input logic [7:0] a_hi,
  input logic [7:0] b_lo,
  input logic [7:0] b_hi,
  input logic       wrap_a,
  input logic       tick_a,
  input logic       ovf0_flag,
  input logic       ovf1_flag,
  input logic       baud_tick
);

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == 3'd5);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!ovf0_flag && !ovf1_flag && !baud_tick)); // R9

  AST_PRESCALE_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick_a |=> !tick_a); // R1

  AST_FLAG_A_FROM_WRAP: assert property (@(posedge clk) disable iff (rst)
    ($rose(ovf0_flag) && !$past(ctrl_wr)) |-> $past(wrap_a)); // R3

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!run_a && !wr_en && mode_a != 2'd3) |=> $stable({a_hi, a_lo})); // R4

  AST_SPLIT_B_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (mode_a == 2'd3 && mode_b == 2'd3 && !wr_en) |=> $stable({b_hi, b_lo})); // R7

  AST_BAUD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    baud_tick |=> !baud_tick); // R8

endmodule

bind tmr_pair tmr_pair_chk i_tmr_pair_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .mode_a   (cfg[0].mode),
  .mode_b   (cfg[1].mode),
  .run_a    (run[0]),
  .a_lo     (a_lo),
  .a_hi     (a_hi),
  .b_lo     (b_lo),
  .b_hi     (b_hi),
  .wrap_a   (wrap[0]),
  .tick_a   (ps_tick[0]),
  .ovf0_flag(ovf0_flag),
  .ovf1_flag(ovf1_flag),
  .baud_tick(baud_tick)
);

// File: tb/test_tmr_pair.sv
module test_tmr_pair;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       cnt_pin0 = 1'b1, cnt_pin1 = 1'b1;
  logic       gate_pin0 = 1'b0, gate_pin1 = 1'b0;
  logic       ovf0_flag, ovf1_flag, baud_tick;

  int n_checks = 0;
  int n_fail   = 0;
  int baud_cnt = 0;
  int baud_dbl = 0;
  logic baud_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_pair i_tmr_pair (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnt_pin0(cnt_pin0), .cnt_pin1(cnt_pin1),
    .gate_pin0(gate_pin0), .gate_pin1(gate_pin1), .ovf0_flag(ovf0_flag),
    .ovf1_flag(ovf1_flag), .baud_tick(baud_tick)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (baud_tick) baud_cnt++;
      if (baud_tick && baud_prev) baud_dbl++;
    end
    baud_prev <= baud_tick;
  end

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    rd_addr = 3'(a);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  // the two reads sample exactly 'cycles' clocks apart
  task automatic delta(int a, int cycles, output int d);
    int v0, v1;
    rd(a, v0);
    repeat (cycles - 1) @(negedge clk);
    rd(a, v1);
    d = (v1 - v0) & 255;
  endtask

  task automatic set_pin(int idx, logic v);
    if (idx == 0) cnt_pin0 = v; else cnt_pin1 = v;
  endtask

  task automatic edges(int idx, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); set_pin(idx, 1'b0);
      repeat ($urandom_range(3, 1)) @(negedge clk);
      set_pin(idx, 1'b1);
      repeat ($urandom_range(3, 1)) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  // stepwise reference: returns {wraps, hi, lo}
  function automatic int model(int mode, int lo, int hi, int n);
    int w = 0;
    for (int i = 0; i < n; i++) begin
      case (mode)
        0: if ((lo & 31) == 31) begin
             lo = lo & 8'hE0;
             if (hi == 255) begin hi = 0; w++; end else hi++;
           end else lo++;
        1: if (lo == 255) begin
             lo = 0;
             if (hi == 255) begin hi = 0; w++; end else hi++;
           end else lo++;
        default: if (lo == 255) begin lo = hi; w++; end else lo++;
      endcase
    end
    return (w << 16) | (hi << 8) | lo;
  endfunction

  initial begin
    repeat (150000) @(negedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int v, d, exp, b0;
    void'($urandom(32'h1C0DE));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    for (int a = 0; a < 7; a++) begin
      rd(a, v);
      check("R9 reset reg", v, 0);
    end
    check("R9 reset flags", {ovf1_flag, ovf0_flag, baud_tick}, 0);

    // R1 prescale rates, both timers mode 1 timer source
    wr(4, 8'h11);
    wr(5, 8'h05);
    delta(0, 120, d); check("R1 A slow", d, 10);
    delta(2, 120, d); check("R1 B slow", d, 10);
    wr(6, 8'h08);
    delta(0, 120, d); check("R1 A fast", d, 30);
    delta(2, 120, d); check("R1 B slow while A fast", d, 10);
    wr(6, 8'h18);
    delta(2, 120, d); check("R1 B fast", d, 30);
    rd(6, v); check("R9 clock select readback", v, 8'h18);

    // R4 run and gate
    wr(4, 8'h19);
    gate_pin0 = 1'b0; repeat (4) @(negedge clk);
    delta(0, 120, d); check("R4 gate low stops", d, 0);
    gate_pin0 = 1'b1; repeat (4) @(negedge clk);
    delta(0, 120, d); check("R4 gate high counts", d, 30);
    wr(5, 8'h04);
    delta(0, 120, d); check("R4 run clear stops", d, 0);

    // R2 prescale ignored in counter mode
    wr(4, 8'h15);
    wr(5, 8'h01);
    delta(0, 120, d); check("R2 counter mode ignores clock", d, 0);

    // R2 R3 R8 random preloads and edge counts
    for (int it = 0; it < 10; it++) begin
      int t, m, lo, hi, n, res, lo_a, hi_a;
      t  = $urandom_range(1, 0);
      m  = $urandom_range(2, 0);
      lo = $urandom_range(255, 0);
      hi = $urandom_range(255, 0);
      if (it < 3) begin lo = 8'hFF; hi = (m == 2) ? hi : 8'hFF; end
      n  = $urandom_range(40, 1);
      wr(5, 0);
      wr(6, $urandom_range(255, 0));
      if (t == 0) wr(4, 8'h10 | 4 | m);
      else        wr(4, ((4 | m) << 4) | 8'h01);
      lo_a = t ? 2 : 0;
      hi_a = t ? 3 : 1;
      wr(lo_a, lo);
      wr(hi_a, hi);
      b0 = baud_cnt;
      wr(5, t ? 8'h04 : 8'h01);
      edges(t, n);
      res = model(m, lo, hi, n);
      rd(lo_a, v); check("R2 R3 random low byte", v, res & 255);
      rd(hi_a, v); check("R3 random high byte", v, (res >> 8) & 255);
      check("R3 random flag", t ? ovf1_flag : ovf0_flag, (res >> 16) != 0);
      if (t == 1) check("R8 baud pulses", baud_cnt - b0, res >> 16);
    end

    // R5 write wins over a same-cycle increment
    wr(5, 0); wr(4, 8'h15); wr(0, 8'h10); wr(5, 8'h01);
    repeat (4) @(negedge clk);
    @(negedge clk); cnt_pin0 = 1'b0;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h55;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk); cnt_pin0 = 1'b1;
    repeat (4) @(negedge clk);
    rd(0, v); check("R5 write beats increment", v, 8'h55);
    wr(5, 8'h02); check("R5 software sets flag", ovf0_flag, 1);
    wr(5, 8'h00); check("R5 software clears flag", ovf0_flag, 0);

    // R6 split mode, timer B held in mode 3
    wr(6, 0);
    wr(4, 8'h37);
    wr(5, 8'h05);
    delta(1, 120, d); check("R6 high byte counts clock under run B", d, 10);
    wr(5, 8'h01);
    delta(1, 120, d); check("R6 high byte stops without run B", d, 0);
    rd(0, v); edges(0, 5); rd(0, d);
    check("R6 low byte counts pin edges", (d - v) & 255, 5);
    wr(1, 8'hFF); wr(5, 8'h05);
    repeat (20) @(negedge clk);
    check("R6 high byte wrap sets flag B", ovf1_flag, 1);
    check("R6 flag A untouched", ovf0_flag, 0);
    wr(5, 8'h01);
    wr(0, 8'hFF); edges(0, 1);
    check("R6 low byte wrap sets flag A", ovf0_flag, 1);
    rd(0, v); check("R6 low byte wrapped", v, 0);

    // R7 timer B during split
    wr(5, 8'h01);
    delta(2, 120, d); check("R7 B mode 3 holds", d, 0);
    wr(4, 8'h17);
    delta(2, 120, d); check("R7 B runs without run bit", d, 10);
    gate_pin1 = 1'b0;
    wr(4, 8'h97); repeat (4) @(negedge clk);
    delta(2, 120, d); check("R7 B gate still applies", d, 0);
    wr(4, 8'h67); wr(2, 8'hFF); wr(3, 8'hA0); wr(5, 8'h01);
    b0 = baud_cnt;
    edges(1, 1);
    rd(2, v); check("R7 B reload in split", v, 8'hA0);
    check("R7 B wrap leaves flag B", ovf1_flag, 0);
    check("R8 baud pulse in split", baud_cnt - b0, 1);
    check("R8 baud single cycle", baud_dbl, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule